// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character, written into a single holding register, into an asynchronous serial frame on a one-bit line. The frame has a low start bit, then 7, 8 or 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. A one-cycle `baud_tick_i` strobe marks bit boundaries, and each bit of the frame occupies exactly one strobe period.

Two status flags form the handshake with the surrounding status logic. `tx_empty_o` shows that the holding register can take a new character. `tx_done_o` shows that the last frame has fully left the line. The word length comes from two control bits that are not adjacent in the control word. One of their four codes is reserved. The stop-bit selector accepts only two of its four codes. If either field holds an unsupported code, the block raises `cfg_err_o` and does not start a new frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd_o` is 1 and both `tx_empty_o` and `tx_done_o` are 1.
- R2: A write (`wr_i`=1) while `tx_empty_o`=1 stores `wr_data_i` and clears both `tx_empty_o` and `tx_done_o` on the next cycle. A write while `tx_empty_o`=0 is ignored, and the character stored earlier is the one that is sent.
- R3: No frame starts while `tx_en_i`=0. Once `tx_en_i`=1 and a character is held, the frame starts on the next `baud_tick_i`.
- R4: A frame is a 0 start bit, then the data bits LSB first, then the stop bits at 1. `txd_o` changes only on a `baud_tick_i` cycle, so each bit lasts one strobe period.
- R5: The word length code is {`wlen_hi_i`,`wlen_lo_i`]: 00 selects 8 data bits, 01 selects 9, and 10 selects 7. Data bits above the selected length are not sent.
- R6: With `par_en_i`=1, a parity bit follows the last data bit. It is computed over the sent data bits only. It is even parity when `par_odd_i`=0 and odd parity when `par_odd_i`=1.
- R7: A `stop_sel_i` of 00 gives one stop bit. A `stop_sel_i` of 10 gives two stop bits.
- R8: `cfg_err_o` is 1 when the word length code is 11 or `stop_sel_i` is 01 or 11. While it is 1, no new frame starts and the held character waits.
- R9: At the end of the last stop bit, `tx_empty_o` and `tx_done_o` are set together, and the line stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Bit-period strobe, one cycle wide |
| tx_en_i | input | 1 | Transmitter enable |
| wlen_hi_i | input | 1 | Word length code, upper bit |
| wlen_lo_i | input | 1 | Word length code, lower bit |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel_i | input | 2 | Stop-bit code |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 9 | Character to send |
| txd_o | output | 1 | Serial line |
| tx_empty_o | output | 1 | Holding register empty |
| tx_done_o | output | 1 | Transmission complete |
| cfg_err_o | output | 1 | Unsupported word length or stop-bit code |

## Verification
The assertions check on every cycle the rules that hold at each clock edge: a write to an empty register clears both flags, a frame begins with a low bit, the line moves only on a strobe, no frame starts while the block is disabled or misconfigured, and the two flags rise together. The bit content of each frame can only be shown by the bench scenarios. That content is the data order, how each word length truncates the character, the parity value for each sense, and the stop-bit count. The bench scenarios also show that a write to a full register is dropped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W  = 9;
  localparam int unsigned FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned NB_W    = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    WL_8   = 2'b00,
    WL_9   = 2'b01,
    WL_7   = 2'b10,
    WL_RSV = 2'b11
  } wlen_e;

  typedef enum logic [1:0] {
    ST_ONE = 2'b00,
    ST_TWO = 2'b10
  } stop_e;
endpackage

// File: rtl/uart_tx_cfg_dec.sv
module uart_tx_cfg_dec
  import uart_tx_pkg::*;
(
  input  logic            wlen_hi_i,
  input  logic            wlen_lo_i,
  input  logic [1:0]      stop_sel_i,
  output logic [NB_W-1:0] nbits_o,
  output logic            two_stop_o,
  output logic            cfg_err_o
);
  logic wl_bad, st_bad;

  always_comb begin
    wl_bad = 1'b0;
    unique case (wlen_e'({wlen_hi_i, wlen_lo_i}))
      WL_8:    nbits_o = NB_W'(8);
      WL_9:    nbits_o = NB_W'(9);
      WL_7:    nbits_o = NB_W'(7);
      default: begin nbits_o = NB_W'(8); wl_bad = 1'b1; end
    endcase
  end

  always_comb begin
    st_bad     = 1'b0;
    two_stop_o = 1'b0;
    case (stop_sel_i)
      ST_ONE:  two_stop_o = 1'b0;
      ST_TWO:  two_stop_o = 1'b1;
      default: st_bad = 1'b1;
    endcase
  end

  assign cfg_err_o = wl_bad | st_bad;
endmodule

// File: rtl/uart_tx_frame_build.sv
module uart_tx_frame_build
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  logic [NB_W-1:0]    nbits_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   frame_len_o
);
  logic [DATA_W-1:0] used;
  logic              par_bit;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) used[i] = (i < int'(nbits_i)) ? data_i[i] : 1'b0;
    par_bit = (^used) ^ par_odd_i;
    // bit 0 leaves first; unfilled tail stays high (stop bits / idle)
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(nbits_i)) frame_o[i+1] = data_i[i];
    if (par_en_i) frame_o[int'(nbits_i) + 1] = par_bit;
    frame_len_o = CNT_W'(2 + int'(nbits_i) + int'(par_en_i) + int'(two_stop_i));
  end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               txd_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (!busy_q && start_i) begin
          sh_q   <= frame_i;
          cnt_q  <= len_i;
          busy_q <= 1'b1;
        end else if (busy_q) begin
          if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            sh_q   <= '1;
          end else begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      end
    end
  end

  assign txd_o  = sh_q[0];
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_start_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !txd_o);
  assert_bit_paced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(txd_o));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        baud_tick_i,
  input  logic        tx_en_i,
  input  logic        wlen_hi_i,
  input  logic        wlen_lo_i,
  input  logic        par_en_i,
  input  logic        par_odd_i,
  input  logic [1:0]  stop_sel_i,
  input  logic        wr_i,
  input  logic [8:0]  wr_data_i,
  output logic        txd_o,
  output logic        tx_empty_o,
  output logic        tx_done_o,
  output logic        cfg_err_o
);
  logic [DATA_W-1:0]  hold_q;
  logic               txe_q, tc_q;
  logic [NB_W-1:0]    nbits;
  logic               two_stop, cfg_err;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;
  logic               busy, done, start;

  uart_tx_cfg_dec u_dec (
    .wlen_hi_i (wlen_hi_i),
    .wlen_lo_i (wlen_lo_i),
    .stop_sel_i(stop_sel_i),
    .nbits_o   (nbits),
    .two_stop_o(two_stop),
    .cfg_err_o (cfg_err)
  );

  uart_tx_frame_build u_build (
    .data_i     (hold_q),
    .nbits_i    (nbits),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop),
    .frame_o    (frame),
    .frame_len_o(frame_len)
  );

  assign start = tx_en_i && !txe_q && !cfg_err;

  uart_tx_serializer u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .start_i(start),
    .frame_i(frame),
    .len_i  (frame_len),
    .txd_o  (txd_o),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      txe_q  <= 1'b1;
      tc_q   <= 1'b1;
    end else if (wr_i && txe_q) begin
      hold_q <= wr_data_i;
      txe_q  <= 1'b0;
      tc_q   <= 1'b0;
    end else if (done) begin
      txe_q <= 1'b1;
      tc_q  <= 1'b1;
    end
  end

  assign tx_empty_o = txe_q;
  assign tx_done_o  = tc_q;
  assign cfg_err_o  = cfg_err;

  assert_load_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_empty_o) |=> (!tx_empty_o && !tx_done_o));
  assert_hold_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !busy) |=> !busy);
  assert_cfg_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !busy) |=> !busy);
  assert_flags_together_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> (tx_done_o && txd_o));
endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tx_en = 1'b0;
  logic wl_hi = 1'b0, wl_lo = 1'b0, pe = 1'b0, po = 1'b0, wr = 1'b0;
  logic [1:0] stp = 2'b00;
  logic [8:0] wdat = '0;
  logic txd, empty, done, cerr;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .tx_en_i(tx_en),
    .wlen_hi_i(wl_hi), .wlen_lo_i(wl_lo), .par_en_i(pe), .par_odd_i(po),
    .stop_sel_i(stp), .wr_i(wr), .wr_data_i(wdat),
    .txd_o(txd), .tx_empty_o(empty), .tx_done_o(done), .cfg_err_o(cerr)
  );

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 0);
      c = (c + 1) % TICK_DIV;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic h, input logic l);
    return ({h, l} == 2'b01) ? 9 : ({h, l} == 2'b10) ? 7 : 8;
  endfunction

  task automatic do_write(input logic [8:0] d);
    @(negedge clk); wr = 1'b1; wdat = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // receives one frame off the line and compares every bit with the model
  task automatic expect_frame(input logic [8:0] d, input string req);
    int nb = nbits_of(wl_hi, wl_lo);
    int len = 1 + nb + int'(pe) + ((stp == 2'b10) ? 2 : 1);
    int par = int'(po);
    int w = 0;
    for (int i = 0; i < nb; i++) par ^= int'(d[i]);
    while (txd !== 1'b0 && w < 40) begin @(negedge clk); w++; end
    chk({req, " start seen"}, int'(txd), 0);
    repeat (2) @(negedge clk);
    for (int b = 0; b < len; b++) begin
      int e = 1;
      if (b == 0) e = 0;
      else if (b <= nb) e = int'(d[b-1]);
      else if (pe && b == nb + 1) e = par;
      chk($sformatf("%s bit %0d", req, b), int'(txd), e);
      if (b == 0) chk({req, " R2 empty low in frame"}, int'(empty), 0);
      repeat (TICK_DIV) @(negedge clk);
    end
    chk({req, " R9 empty"}, int'(empty), 1);
    chk({req, " R9 done"}, int'(done), 1);
    chk({req, " R9 idle high"}, int'(txd), 1);
  endtask

  task automatic t_reset;
    chk("R1 txd", int'(txd), 1);
    chk("R1 empty", int'(empty), 1);
    chk("R1 done", int'(done), 1);
    chk("R1 cfg_err", int'(cerr), 0);
  endtask

  task automatic t_frame(input logic h, input logic l, input logic p_en, input logic p_odd,
                         input logic [1:0] s, input logic [8:0] d, input string req);
    wl_hi = h; wl_lo = l; pe = p_en; po = p_odd; stp = s; tx_en = 1'b1;
    @(negedge clk); wr = 1'b1; wdat = d;
    @(negedge clk); wr = 1'b0;
    chk({req, " R2 empty cleared"}, int'(empty), 0);
    chk({req, " R2 done cleared"}, int'(done), 0);
    expect_frame(d, req);
  endtask

  task automatic t_disabled_and_ignore;
    wl_hi = 0; wl_lo = 0; pe = 0; po = 0; stp = 2'b00; tx_en = 1'b0;
    do_write(9'h0A5);
    do_write(9'h03C);
    repeat (40) begin
      @(negedge clk);
      if (txd !== 1'b1) break;
    end
    chk("R3 no frame while disabled", int'(txd), 1);
    chk("R3 still holding", int'(empty), 0);
    tx_en = 1'b1;
    expect_frame(9'h0A5, "R2 ignored second write / R3 enable");
  endtask

  task automatic t_cfg_err;
    tx_en = 1'b0; wl_hi = 1; wl_lo = 1; stp = 2'b00; pe = 0;
    @(negedge clk);
    chk("R8 word code 11", int'(cerr), 1);
    wl_hi = 0; wl_lo = 0; stp = 2'b11;
    @(negedge clk);
    chk("R8 stop code 11", int'(cerr), 1);
    stp = 2'b01;
    @(negedge clk);
    chk("R8 stop code 01", int'(cerr), 1);
    do_write(9'h05A);
    tx_en = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (txd !== 1'b1) break;
    end
    chk("R8 blocked line", int'(txd), 1);
    chk("R8 blocked held", int'(empty), 0);
    stp = 2'b10;
    @(negedge clk);
    chk("R8 cleared", int'(cerr), 0);
    expect_frame(9'h05A, "R8 after fix R7");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_frame(0, 0, 0, 0, 2'b00, 9'h0B3, "R4 R5 8bit");
    t_frame(0, 1, 0, 0, 2'b00, 9'h1A5, "R5 9bit");
    t_frame(1, 0, 0, 0, 2'b00, 9'h1D5, "R5 7bit truncates");
    t_frame(0, 0, 1, 0, 2'b00, 9'h0B3, "R6 even");
    t_frame(0, 0, 1, 1, 2'b00, 9'h0B3, "R6 odd");
    t_frame(1, 0, 1, 0, 2'b00, 9'h1F0, "R6 7bit parity");
    t_frame(0, 1, 1, 1, 2'b10, 9'h101, "R6 R7 9bit two stop");
    t_frame(0, 0, 0, 0, 2'b10, 9'h000, "R7 two stop");
    t_disabled_and_ignore();
    t_cfg_err();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule